// File: doc/BRIEF.md
# Multiply and Long Multiply-Accumulate Unit

This unit multiplies two 32-bit factors. A 4-bit operation code chooses the form of the result. The result can be the low word of the product, the low word of the product plus an accumulator word, the full unsigned 64-bit product with or without a 64-bit accumulator added, or the full signed 64-bit product. A flag-setting variant of the truncated multiply updates the sign and zero flags and keeps the carry and overflow flags unchanged.

A one-cycle `start` pulse loads all operands, the operation code and the old flags into a capture register. The arithmetic is computed from that register. The result then moves through a fixed delay line, and `done` rises exactly `LATENCY` rising edges after the edge that sampled `start`. A new operation may start on every cycle. Each operation keeps its own operands, so results come out in issue order, one per cycle.

Top module: `mac_long_unit`

## Requirements
- R1: Operation code 0x0 returns the low 32 bits of `mul_a*mul_b` on `res_lo`, returns zero on `res_hi`, and passes the old flags through unchanged.
- R2: Operation code 0x1 returns the same result as 0x0. It sets `flags_out[3]` (N) from bit 31 of the result and sets `flags_out[2]` (Z) when the 32-bit result is zero. It copies `flags_out[1]` (C) and `flags_out[0]` (V) from `flags_in`.
- R3: Operation code 0x2 returns the low 32 bits of `mul_a*mul_b + acc_lo` on `res_lo` and returns zero on `res_hi`. `acc_hi` has no effect.
- R4: Operation code 0x8 returns the unsigned 64-bit product, with the low word on `res_lo` and the high word on `res_hi`.
- R5: Operation code 0xA returns the unsigned 64-bit product plus `{acc_hi, acc_lo}`, modulo 2^64.
- R6: Operation code 0xC returns the 64-bit product of the two factors read as two's complement numbers.
- R7: Any other operation code raises `illegal` with `done`, returns zero on both result words, and passes the flags unchanged. `illegal` stays low for the six legal codes.
- R8: `done` is high for exactly one cycle per start. It rises `LATENCY` rising edges after the edge that samples `start`, counting that edge as the first, and it is low at all other times.
- R9: Operands, operation code and flags are taken on the start edge, so later changes to the inputs do not affect that result. Starts on consecutive cycles give results on consecutive cycles, in order.
- R10: While reset is held and just after it is released, `done`, `illegal`, `res_lo`, `res_hi` and `flags_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Loads operands and operation code on this edge |
| op | input | 4 | Operation code |
| mul_a | input | 32 | First factor |
| mul_b | input | 32 | Second factor |
| acc_hi | input | 32 | Accumulator high word |
| acc_lo | input | 32 | Accumulator low word |
| flags_in | input | 4 | Old flags {N,Z,C,V} |
| res_lo | output | 32 | Result low word |
| res_hi | output | 32 | Result high word |
| flags_out | output | 4 | Next flags {N,Z,C,V} |
| done | output | 1 | Result valid, one-cycle pulse |
| illegal | output | 1 | Unsupported operation code, valid with done |

## Verification
Every result word, the next flags and the illegal indication become valid together with `done`. That is LATENCY rising edges after the start edge: one edge loads the capture register and LATENCY-1 edges move the result through the delay line. The bench drives each start at a falling edge and counts the same number of rising edges. It samples on the falling edge that follows and also checks that `done` is low one cycle before and one cycle after. The back-to-back test changes the inputs on every cycle. It computes for each falling edge which issued operation, if any, is due there.

// File: rtl/mlm_pkg.sv
package mlm_pkg;
  localparam logic [3:0] OPC_MUL    = 4'h0;
  localparam logic [3:0] OPC_MUL_NZ = 4'h1;
  localparam logic [3:0] OPC_MLA    = 4'h2;
  localparam logic [3:0] OPC_UMULL  = 4'h8;
  localparam logic [3:0] OPC_UMLAL  = 4'h A;
  localparam logic [3:0] OPC_SMULL  = 4'hC;

  typedef enum logic [2:0] {
    K_TRUNC, K_TRUNC_ACC, K_ULONG, K_ULONG_ACC, K_SLONG, K_BAD
  } mul_kind_e;
endpackage

// File: rtl/mlm_decode.sv
module mlm_decode
  import mlm_pkg::*;
(
  input  logic [3:0] op,
  output mul_kind_e  kind,
  output logic       set_nz
);
  always_comb begin
    set_nz = 1'b0;
    case (op)
      OPC_MUL:    kind = K_TRUNC;
      OPC_MUL_NZ: begin kind = K_TRUNC; set_nz = 1'b1; end
      OPC_MLA:    kind = K_TRUNC_ACC;
      OPC_UMULL:  kind = K_ULONG;
      OPC_UMLAL:  kind = K_ULONG_ACC;
      OPC_SMULL:  kind = K_SLONG;
      default:    kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/mlm_arith.sv
module mlm_arith
  import mlm_pkg::*;
#(
  parameter int DW = 32
) (
  input  mul_kind_e      kind,
  input  logic           set_nz,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  input  logic [DW-1:0]  acc_hi,
  input  logic [DW-1:0]  acc_lo,
  input  logic [3:0]     flags_old,
  output logic [DW-1:0]  res_lo,
  output logic [DW-1:0]  res_hi,
  output logic [3:0]     flags_new,
  output logic           bad
);
  localparam int PW = 2 * DW;

  function automatic logic [PW-1:0] f_umul(logic [DW-1:0] x, logic [DW-1:0] y);
    return {{DW{1'b0}}, x} * {{DW{1'b0}}, y};
  endfunction

  function automatic logic [PW-1:0] f_smul(logic [DW-1:0] x, logic [DW-1:0] y);
    return {{DW{x[DW-1]}}, x} * {{DW{y[DW-1]}}, y};
  endfunction

  function automatic logic [3:0] f_nz(logic [3:0] old, logic [DW-1:0] r);
    return {r[DW-1], (r == '0), old[1:0]};
  endfunction

  logic [PW-1:0] uprod;
  logic [PW-1:0] wide;

  always_comb begin
    uprod = f_umul(a, b);
    bad   = 1'b0;
    case (kind)
      K_TRUNC:     wide = {{DW{1'b0}}, uprod[DW-1:0]};
      K_TRUNC_ACC: wide = {{DW{1'b0}}, uprod[DW-1:0] + acc_lo};
      K_ULONG:     wide = uprod;
      K_ULONG_ACC: wide = uprod + {acc_hi, acc_lo};
      K_SLONG:     wide = f_smul(a, b);
      default: begin wide = '0; bad = 1'b1; end
    endcase
    res_lo    = wide[DW-1:0];
    res_hi    = wide[PW-1:DW];
    flags_new = set_nz ? f_nz(flags_old, wide[DW-1:0]) : flags_old;
  end
endmodule

// File: rtl/mlm_delay.sv
module mlm_delay #(
  parameter int W = 8,
  parameter int D = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  logic [D:0]   v_chain;
  logic [W-1:0] d_chain [D+1];

  assign v_chain[0] = in_valid;
  assign d_chain[0] = in_data;

  for (genvar g = 0; g < D; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_chain[g+1] <= 1'b0;
        d_chain[g+1] <= '0;
      end else begin
        v_chain[g+1] <= v_chain[g];
        d_chain[g+1] <= d_chain[g];
      end
    end
  end

  assign out_valid = v_chain[D];
  assign out_data  = d_chain[D];
endmodule

// File: rtl/mac_long_unit.sv
module mac_long_unit
  import mlm_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int LATENCY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] mul_a,
  input  logic [DATA_W-1:0] mul_b,
  input  logic [DATA_W-1:0] acc_hi,
  input  logic [DATA_W-1:0] acc_lo,
  input  logic [3:0]        flags_in,
  output logic [DATA_W-1:0] res_lo,
  output logic [DATA_W-1:0] res_hi,
  output logic [3:0]        flags_out,
  output logic              done,
  output logic              illegal
);
  localparam int DW     = DATA_W;
  localparam int LAT    = LATENCY;
  localparam int STAGES = LAT - 1;
  localparam int PAY_W  = 2 * DW + 13;

  // capture register
  logic          cap_valid;
  logic [3:0]    cap_op;
  logic [DW-1:0] cap_a, cap_b, cap_hi, cap_lo;
  logic [3:0]    cap_flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_valid <= 1'b0;
      cap_op    <= '0;
      cap_a     <= '0;
      cap_b     <= '0;
      cap_hi    <= '0;
      cap_lo    <= '0;
      cap_flags <= '0;
    end else begin
      cap_valid <= start;
      if (start) begin
        cap_op    <= op;
        cap_a     <= mul_a;
        cap_b     <= mul_b;
        cap_hi    <= acc_hi;
        cap_lo    <= acc_lo;
        cap_flags <= flags_in;
      end
    end
  end

  mul_kind_e     kind;
  logic          set_nz;
  logic [DW-1:0] calc_lo, calc_hi;
  logic [3:0]    calc_flags;
  logic          calc_bad;

  mlm_decode u_dec (
    .op     (cap_op),
    .kind   (kind),
    .set_nz (set_nz)
  );

  mlm_arith #(.DW(DW)) u_arith (
    .kind      (kind),
    .set_nz    (set_nz),
    .a         (cap_a),
    .b         (cap_b),
    .acc_hi    (cap_hi),
    .acc_lo    (cap_lo),
    .flags_old (cap_flags),
    .res_lo    (calc_lo),
    .res_hi    (calc_hi),
    .flags_new (calc_flags),
    .bad       (calc_bad)
  );

  logic [PAY_W-1:0] pay_in, pay_out;
  logic             out_valid;

  assign pay_in = {calc_bad, cap_op, cap_flags, calc_flags, calc_hi, calc_lo};

  mlm_delay #(.W(PAY_W), .D(STAGES)) u_delay (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (cap_valid),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_data  (pay_out)
  );

  // named wires observed by the checker
  logic       out_bad;
  logic [3:0] out_op;
  logic [3:0] out_old_flags;

  assign out_bad       = pay_out[PAY_W-1];
  assign out_op        = pay_out[PAY_W-2 -: 4];
  assign out_old_flags = pay_out[PAY_W-6 -: 4];
  assign flags_out     = pay_out[2*DW+3 -: 4];
  assign res_hi        = pay_out[2*DW-1 -: DW];
  assign res_lo        = pay_out[DW-1:0];
  assign done          = out_valid;
  assign illegal       = out_valid & out_bad;
endmodule

// File: rtl/mlm_chk.sv
module mlm_chk #(
  parameter int DW  = 32,
  parameter int LAT = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          done,
  input logic          illegal,
  input logic [DW-1:0] res_lo,
  input logic [DW-1:0] res_hi,
  input logic [3:0]    flags_out,
  input logic [3:0]    out_op,
  input logic [3:0]    out_old_flags
);
  localparam int CW = $clog2(LAT + 2) + 1;
  logic [CW-1:0] inflight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else        inflight <= inflight + CW'(start) - CW'(done);
  end

  AST_DONE_HAS_START: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> inflight != '0); // R8
  AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= CW'(LAT)); // R9
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (res_lo == '0 && res_hi == '0 && flags_out == out_old_flags)); // R7
  AST_NZ_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && out_op == 4'h1) |-> (flags_out[3] == res_lo[DW-1] &&
                                  flags_out[2] == (res_lo == '0) &&
                                  flags_out[1:0] == out_old_flags[1:0])); // R2
  AST_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && out_op != 4'h1) |-> flags_out == out_old_flags); // R1
  AST_SHORT_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && out_op <= 4'h2) |-> res_hi == '0); // R3
  AST_ILLEGAL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done); // R7
endmodule

bind mac_long_unit mlm_chk #(.DW(DW), .LAT(LAT)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .done          (done),
  .illegal       (illegal),
  .res_lo        (res_lo),
  .res_hi        (res_hi),
  .flags_out     (flags_out),
  .out_op        (out_op),
  .out_old_flags (out_old_flags)
);

// File: tb/mac_long_unit_tb.sv
module mac_long_unit_tb;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  op = '0;
  logic [31:0] mul_a = '0, mul_b = '0, acc_hi = '0, acc_lo = '0;
  logic [3:0]  flags_in = '0;
  logic [31:0] res_lo, res_hi;
  logic [3:0]  flags_out;
  logic        done, illegal;

  always #5 clk = ~clk;

  mac_long_unit #(.DATA_W(32), .LATENCY(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .mul_a(mul_a), .mul_b(mul_b), .acc_hi(acc_hi), .acc_lo(acc_lo),
    .flags_in(flags_in), .res_lo(res_lo), .res_hi(res_hi),
    .flags_out(flags_out), .done(done), .illegal(illegal)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a, b, hi, lo;
    logic [3:0]  fl;
    logic [31:0] e_lo, e_hi;
    logic [3:0]  e_fl;
    logic        e_ill;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{4'h0, 32'd3,        32'd5,        32'h0,        32'h0,        4'b0011, 32'd15,       32'h0,        4'b0011, 1'b0}, // R1
    '{4'h0, 32'h10000,    32'h10000,    32'h0,        32'h0,        4'b0000, 32'h0,        32'h0,        4'b0000, 1'b0}, // R1
    '{4'h1, 32'hFFFFFFFF, 32'd1,        32'h0,        32'h0,        4'b0111, 32'hFFFFFFFF, 32'h0,        4'b1011, 1'b0}, // R2
    '{4'h1, 32'h10000,    32'h10000,    32'h0,        32'h0,        4'b1000, 32'h0,        32'h0,        4'b0100, 1'b0}, // R2
    '{4'h2, 32'd4,        32'd5,        32'h1234,     32'd7,        4'b0000, 32'h1B,       32'h0,        4'b0000, 1'b0}, // R3
    '{4'h2, 32'hFFFFFFFF, 32'd1,        32'h0,        32'd2,        4'b1100, 32'h1,        32'h0,        4'b1100, 1'b0}, // R3
    '{4'h8, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0,        32'h0,        4'b0000, 32'h1,        32'hFFFFFFFE, 4'b0000, 1'b0}, // R4
    '{4'h8, 32'h10000,    32'h30000,    32'h55,       32'h66,       4'b0001, 32'h0,        32'h3,        4'b0001, 1'b0}, // R4
    '{4'hA, 32'd2,        32'd3,        32'h1,        32'hFFFFFFFF, 4'b0000, 32'h5,        32'h2,        4'b0000, 1'b0}, // R5
    '{4'hA, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 4'b0010, 32'h0,        32'hFFFFFFFE, 4'b0010, 1'b0}, // R5
    '{4'hC, 32'hFFFFFFFF, 32'd2,        32'h0,        32'h0,        4'b0000, 32'hFFFFFFFE, 32'hFFFFFFFF, 4'b0000, 1'b0}, // R6
    '{4'hC, 32'h80000000, 32'h80000000, 32'h0,        32'h0,        4'b0000, 32'h0,        32'h40000000, 4'b0000, 1'b0}, // R6
    '{4'hC, 32'd7,        32'hFFFFFFFD, 32'h0,        32'h0,        4'b0000, 32'hFFFFFFEB, 32'hFFFFFFFF, 4'b0000, 1'b0}, // R6
    '{4'h3, 32'd3,        32'd3,        32'h0,        32'h0,        4'b1010, 32'h0,        32'h0,        4'b1010, 1'b1}, // R7
    '{4'h9, 32'd9,        32'd9,        32'h1,        32'h1,        4'b0101, 32'h0,        32'h0,        4'b0101, 1'b1}  // R7
  };

  int unsigned n_checks = 0;
  int unsigned n_fail = 0;
  bit          finished = 1'b0;

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic [3:0] o, logic [31:0] a, logic [31:0] b,
                       logic [31:0] h, logic [31:0] l, logic [3:0] f);
    op = o; mul_a = a; mul_b = b; acc_hi = h; acc_lo = l; flags_in = f;
  endtask

  task automatic scramble();
    drive(4'hC, 32'hDEADBEEF, 32'h12345678, 32'hA5A5A5A5, 32'h5A5A5A5A, 4'b1111);
  endtask

  task automatic run_vec(vec_t v, string req);
    @(negedge clk);
    drive(v.op, v.a, v.b, v.hi, v.lo, v.fl);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    scramble(); // R9: later input changes must not matter
    repeat (LAT - 2) @(posedge clk);
    if (LAT > 2) @(negedge clk);
    check("R8", "done early", 64'(done), 64'd0);
    @(posedge clk);
    @(negedge clk);
    check("R8", "done due", 64'(done), 64'd1);
    check(req, "res_lo", 64'(res_lo), 64'(v.e_lo));
    check(req, "res_hi", 64'(res_hi), 64'(v.e_hi));
    check(req, "flags", 64'(flags_out), 64'(v.e_fl));
    check("R7", "illegal", 64'(illegal), 64'(v.e_ill));
    @(posedge clk);
    @(negedge clk);
    check("R8", "done single pulse", 64'(done), 64'd0);
  endtask

  // back-to-back stimulus and expected results
  logic [3:0]  bb_op [3] = '{4'h8, 4'hC, 4'h0};
  logic [31:0] bb_a  [3] = '{32'd2, 32'hFFFFFFFF, 32'h10};
  logic [31:0] bb_b  [3] = '{32'd3, 32'hFFFFFFFF, 32'h10};
  logic [31:0] bb_lo [3] = '{32'd6, 32'd1, 32'h100};

  initial begin
    repeat (3) @(negedge clk);
    check("R10", "done in reset", 64'(done), 64'd0);
    check("R10", "res in reset", {res_hi, res_lo}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "done after reset", 64'(done), 64'd0);
    check("R10", "illegal after reset", 64'(illegal), 64'd0);
    check("R10", "flags after reset", 64'(flags_out), 64'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string req;
      v = TBL[i];
      case (v.op)
        4'h0: req = "R1";
        4'h1: req = "R2";
        4'h2: req = "R3";
        4'h8: req = "R4";
        4'hA: req = "R5";
        4'hC: req = "R6";
        default: req = "R7";
      endcase
      run_vec(v, req);
    end

    // R9: three starts on consecutive cycles, inputs changing every cycle
    for (int c = 0; c < LAT + 4; c++) begin
      if (c < 3) begin
        drive(bb_op[c], bb_a[c], bb_b[c], 32'h0, 32'h0, 4'b0000);
        start = 1'b1;
      end else begin
        start = 1'b0;
        scramble();
      end
      @(posedge clk);
      @(negedge clk);
      if (c >= LAT - 1 && c <= LAT + 1) begin
        check("R9", "b2b done", 64'(done), 64'd1);
        check("R9", "b2b res_lo", 64'(res_lo), 64'(bb_lo[c-(LAT-1)]));
        check("R9", "b2b res_hi", 64'(res_hi), 64'd0);
      end else begin
        check("R9", "b2b idle", 64'(done), 64'd0);
      end
    end

    // R10: reset mid-flight clears outputs
    @(negedge clk);
    drive(4'h8, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'h0, 4'b1111);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R10", "reset flush done", 64'(done), 64'd0);
    check("R10", "reset flush res", {res_hi, res_lo}, 64'd0);
    rst_n = 1'b1;
    repeat (LAT + 1) @(negedge clk);
    check("R10", "no ghost done", 64'(done), 64'd0);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule